// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned 8-bit operands. It handles one multiplier bit per clock, so a full result takes eight clocks. A one-cycle start pulse captures both operands and clears the 16-bit result register. On each of the next eight clocks, the lowest unconsumed multiplier bit gates the multiplicand. A 9-bit adder adds the gated value to the upper byte of the result register. The register then shifts right by one place as it takes in the new sum. The adder stays at a fixed position and the partial product moves past it.

When the eighth step has been taken, a done flag rises. The result then holds, whatever the operand inputs do, until the next start. A start that arrives while a multiplication is running abandons that multiplication and begins again with the operands present at that moment. The block suits a datapath where area matters more than latency. Such a datapath can accept one result every nine clocks.

Top module: `shamul_top`

## Requirements
- R1: While the active-low `rst_n` is low, `product` is 0 and `done` is 0, and both stay at those values until the first start.
- R2: On the clock after `start` is sampled high, `product` reads 0 and `done` reads 0.
- R3: `done` rises exactly eight clocks after the clock that sampled `start`, and it is still low after the seventh of those clocks.
- R4: When `done` is high, `product` equals the unsigned product of the `mcand` and `mplier` values sampled with `start`. This includes the cases with a zero operand and 255 × 255 = 65025.
- R5: While `done` is high and `start` stays low, `product` and `done` do not change, whatever happens on `mcand` and `mplier`.
- R6: A `start` sampled while a multiplication is in progress abandons it. The new operands are used, and `done` follows eight clocks later with their product.
- R7: Multiplier bits are consumed from bit 0 upward. After k accumulate clocks (1 ≤ k ≤ 8), `product` equals (mcand × (mplier mod 2^k)) shifted left by 8−k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Captures the operands and begins a multiplication |
| mcand | input | 8 | Multiplicand, unsigned |
| mplier | input | 8 | Multiplier, unsigned |
| product | output | 16 | Running partial product; the final result once `done` is high |
| done | output | 1 | High once eight accumulate steps have completed |

## Verification
The hardest situation to reach from the ports is a restart in the middle of a multiplication. Here stale partial-product bits or a half-advanced step counter could leak into the new result. The stimulus starts a multiplication, lets it run a few steps with operands that fill the register with ones, and then pulses start again with different operands. It then checks that the result is clean and that the timing of the done flag is correct. The intermediate value of the register is also compared after every step. This shows that the bits are consumed in order, from bit 0 upward.

// File: rtl/shamul_pkg.sv
package shamul_pkg;

    parameter int unsigned OP_W = 8;

    typedef struct packed {
        logic [OP_W-1:0]   mcand;
        logic [OP_W-1:0]   mplier;
        logic [2*OP_W-1:0] prod;
    } dp_state_t;

endpackage

// File: rtl/shamul_gate.sv
module shamul_gate #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             sel,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    // Per-bit AND gating of the multiplicand by the current multiplier bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign dout[i] = din[i] & sel;
    end

endmodule

// File: rtl/shamul_adder.sv
module shamul_adder #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH:0]   sum
);

    assign sum = {1'b0, a} + {1'b0, b};

endmodule

// File: rtl/shamul_ctrl.sv
module shamul_ctrl #(
    parameter int unsigned STEPS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic step,
    output logic done
);

    localparam int unsigned CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          busy;
        logic          done;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cnt  = '0;
            st_d.busy = 1'b1;
            st_d.done = 1'b0;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign step = st_q.busy & ~start;
    assign done = st_q.done;

endmodule

// File: rtl/shamul_top.sv
module shamul_top
    import shamul_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   mcand,
    input  logic [OP_W-1:0]   mplier,
    output logic [2*OP_W-1:0] product,
    output logic              done
);

    localparam int unsigned PW = 2 * OP_W;

    dp_state_t dp_d, dp_q;

    logic            step;
    logic [OP_W-1:0] gated;
    logic [OP_W:0]   sum;

    shamul_ctrl #(.STEPS(OP_W)) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .step (step),
        .done (done)
    );

    shamul_gate #(.WIDTH(OP_W)) u_gate (
        .sel (dp_q.mplier[0]),
        .din (dp_q.mcand),
        .dout(gated)
    );

    shamul_adder #(.WIDTH(OP_W)) u_add (
        .a  (dp_q.prod[PW-1:OP_W]),
        .b  (gated),
        .sum(sum)
    );

    always_comb begin
        dp_d = dp_q;
        if (start) begin
            dp_d.mcand  = mcand;
            dp_d.mplier = mplier;
            dp_d.prod   = '0;
        end else if (step) begin
            dp_d.mplier = {1'b0, dp_q.mplier[OP_W-1:1]};
            dp_d.prod   = {sum, dp_q.prod[OP_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign product = dp_q.prod;

endmodule

// File: rtl/shamul_checker.sv
module shamul_checker #(
    parameter int unsigned WIDTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [WIDTH-1:0]   mcand,
    input logic [WIDTH-1:0]   mplier,
    input logic [2*WIDTH-1:0] product,
    input logic               done
);

    logic [4:0]         run_cnt;
    logic [WIDTH-1:0]   cap_a, cap_b;
    logic [2*WIDTH-1:0] exp_prod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= 5'd31;
            cap_a   <= '0;
            cap_b   <= '0;
        end else if (start) begin
            run_cnt <= '0;
            cap_a   <= mcand;
            cap_b   <= mplier;
        end else if (run_cnt != 5'd31) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign exp_prod = (2*WIDTH)'(cap_a) * (2*WIDTH)'(cap_b);

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (product == '0 && !done);
        end
    end

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (product == '0 && !done));

    assert_done_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (run_cnt == 5'(WIDTH)));

    assert_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (product == exp_prod));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(product)));

endmodule

bind shamul_top shamul_checker #(.WIDTH(shamul_pkg::OP_W)) u_chk (.*);

// File: tb/shamul_top_test.sv
`timescale 1ns/1ps
module shamul_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  mcand = '0;
    logic [7:0]  mplier = '0;
    logic [15:0] product;
    logic        done;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    shamul_top uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .mcand  (mcand),
        .mplier (mplier),
        .product(product),
        .done   (done)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int partial(input int a, input int b, input int k);
        return ((a * (b & ((1 << k) - 1))) << (8 - k)) & 16'hFFFF;
    endfunction

    task automatic pulse_start(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        mcand = a; mplier = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(product == 16'd0, "R2 product cleared", product, 0);
        check(done == 1'b0, "R2 done cleared", done, 0);
    endtask

    // Full run with per-step comparison (R3, R4, R7)
    task automatic t_run(input int a, input int b);
        pulse_start(a[7:0], b[7:0]);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            check(product == partial(a, b, k), "R7 partial product", product, partial(a, b, k));
            check(done == (k == 8), "R3 done timing", done, (k == 8));
        end
        check(product == a * b, "R4 final product", product, a * b);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(product == 16'd0 && done == 1'b0, "R1 reset state", product, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(product == 16'd0 && done == 1'b0, "R1 idle after reset", product, 0);
    endtask

    task automatic t_hold();
        logic [15:0] kept;
        t_run(173, 94);
        kept = product;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            mcand = 8'(i * 37 + 5); mplier = 8'(255 - i * 11);
            check(product == kept, "R5 product holds", product, kept);
            check(done == 1'b1, "R5 done holds", done, 1);
        end
    endtask

    task automatic t_abort();
        pulse_start(8'hFF, 8'hFF);
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R6 busy before abort", done, 0);
        t_run(19, 200);
        check(done == 1'b1, "R6 done after restart", done, 1);
    endtask

    task automatic t_abort_late();
        pulse_start(8'hAA, 8'h55);
        repeat (7) @(negedge clk);
        t_run(6, 7);
    endtask

    initial begin
        t_reset();
        t_run(3, 5);
        t_run(0, 200);
        t_run(200, 0);
        t_run(255, 255);
        t_run(1, 128);
        t_run(128, 1);
        t_hold();
        t_abort();
        t_abort_late();
        t_run(85, 170);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule